// File: doc/BRIEF.md
# Multi-Channel Ring Command Queue

This block holds queued command words for several channels in one shared word memory. Each channel owns a window of that memory. A setup register gives the window's lowest address (base) and highest address (limit). Each channel keeps its own read and write pointers. A producer pushes a word at the write pointer of the channel it selects. A consumer pops the word at the read pointer of a channel. Both pointers run around the window as a ring.

A debug peek path sits beside the normal traffic. A host writes a peek control word that names a channel and a memory address. It can then read the stored word at that address, and the selected channel's two pointers, without moving anything. A status word per channel reports whether that channel holds no data. A full channel refuses pushes and raises a sticky overflow flag. The flag stays set until the channel is set up again.

Top module: `cmdq_ring_bank`

## Requirements
- R1: After a synchronous active-low reset, channel c owns the window from c*W to c*W+W-1, where W is the memory depth divided by the channel count. Both of its pointers equal that base, every channel is empty, and every overflow flag is clear.
- R2: A setup write carries the base in bits 8:0 and the limit in bits 24:16. From the next cycle it loads both pointers of that channel with the new base and clears its overflow flag. A push or pop to that channel in the same cycle is dropped.
- R3: An accepted push stores the word at the write pointer. The write pointer then moves to the next address, and from the limit it moves back to the base.
- R4: A channel is full when advancing its write pointer would make it equal to the read pointer, so it holds limit minus base words. While a channel is full, push_ready is low for it, a push is not stored, and the push sets that channel's overflow flag. The flag stays set until a setup write to that channel.
- R5: A pop from a non-empty channel gives pop_valid high in the next cycle, with the word at the read pointer on pop_data. The read pointer then advances with the same wrap rule as R3, so words come out in the order they were pushed.
- R6: A pop from an empty channel gives pop_valid low in the next cycle and leaves both pointers unchanged.
- R7: The peek control word holds enable in bit 31, the channel number in bits 18:16 and the word address in bits 8:0. While enable is clear, or the channel number is not below the channel count, both peek outputs read zero.
- R8: peek_ptrs returns the selected channel's read pointer in bits 8:0 and its write pointer in bits 24:16, with all other bits zero. It follows pointer changes in the same cycle.
- R9: peek_data returns the memory word at the peek address. Peek accesses never change any pointer or stored word.
- R10: stat_word reports, in bit 10, whether the channel selected by stat_ch is empty (read pointer equals write pointer). All other bits are zero.
- R11: Pushes, pops and overflow on one channel leave the pointers and flags of every other channel unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Setup register write strobe |
| cfg_ch | input | CH_W | Channel whose setup is written |
| cfg_wdata | input | 32 | Setup word: base 8:0, limit 24:16 |
| push_valid | input | 1 | Push request |
| push_ch | input | CH_W | Channel to push into |
| push_data | input | DATA_W | Word to push |
| push_ready | output | 1 | Selected push channel is not full |
| ovf_flags | output | NUM_CH | Sticky overflow flag per channel |
| pop_req | input | 1 | Pop request |
| pop_ch | input | CH_W | Channel to pop from |
| pop_valid | output | 1 | Popped word present (one cycle after the request) |
| pop_data | output | DATA_W | Popped word |
| peek_we | input | 1 | Peek control write strobe |
| peek_wdata | input | 32 | Peek control: enable 31, channel 18:16, address 8:0 |
| peek_ptrs | output | 32 | Selected read pointer 8:0, write pointer 24:16 |
| peek_data | output | DATA_W | Word at the peek address |
| stat_ch | input | CH_W | Channel whose status is shown |
| stat_word | output | 32 | Status: empty in bit 10 |

## Verification
The bench builds the block with four channels and 16-bit words. Each default window is then 128 words, and one channel's window ends at the top memory address 511. Reprogramming one channel to a four-word window (capacity three) lets a long operation sweep hit full, overflow, empty pops and pointer wrap many times. The bench compares every step against an arithmetic ring model. A second sweep fills the default top window completely, so the write pointer wraps from the last memory address back to the window base.

// File: rtl/cmdq_pkg.sv
// Package: shared field positions and helpers for the ring command queue.
// Assumes every register word is 32 bits and every pointer field is 9 bits.
package cmdq_pkg;

    localparam int FIELD_W        = 9;
    localparam int REG_W          = 32;
    localparam int HI_LSB         = 16;
    localparam int PEEK_EN_BIT    = 31;
    localparam int PEEK_CH_LSB    = 16;
    localparam int PEEK_CH_W      = 3;
    localparam int STAT_EMPTY_BIT = 10;

    typedef logic [FIELD_W-1:0] ptr_t;

    typedef struct packed {
        logic                 en;
        logic [PEEK_CH_W-1:0] ch;
        ptr_t                 addr;
    } peek_sel_t;

    // Low 9-bit field of a register word
    function automatic ptr_t field_lo(input logic [REG_W-1:0] w);
        return w[FIELD_W-1:0];
    endfunction

    // High 9-bit field of a register word
    function automatic ptr_t field_hi(input logic [REG_W-1:0] w);
        return w[HI_LSB +: FIELD_W];
    endfunction

    // Place two 9-bit fields into a register word, all other bits zero
    function automatic logic [REG_W-1:0] pack_pair(input ptr_t lo, input ptr_t hi);
        logic [REG_W-1:0] w;
        w = '0;
        w[FIELD_W-1:0]     = lo;
        w[HI_LSB +: FIELD_W] = hi;
        return w;
    endfunction

    // Ring successor of a pointer inside [base, limit]
    function automatic ptr_t ring_next(input ptr_t p, input ptr_t base, input ptr_t limit);
        return (p == limit) ? base : p + ptr_t'(1);
    endfunction

endpackage

// File: rtl/cmdq_chan_ctl.sv
// Module: one channel's ring state: window bounds, read/write pointers and
// the sticky overflow flag. Assumes base <= limit inside the shared memory.
// A setup load takes priority over push and pop in the same cycle.
module cmdq_chan_ctl
    import cmdq_pkg::*;
#(
    parameter ptr_t RST_BASE  = '0,
    parameter ptr_t RST_LIMIT = '0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_load,
    input  ptr_t cfg_base,
    input  ptr_t cfg_limit,
    input  logic push_req,
    input  logic pop_req,
    output ptr_t rd_ptr,
    output ptr_t wr_ptr,
    output logic empty,
    output logic full,
    output logic push_fire,
    output logic pop_fire,
    output logic ovf
);

    ptr_t base_q, limit_q;
    ptr_t rd_q, wr_q;
    ptr_t rd_nxt, wr_nxt;
    logic ovf_q;

    // Next-pointer and occupancy decode
    always_comb begin
        wr_nxt    = ring_next(wr_q, base_q, limit_q);
        rd_nxt    = ring_next(rd_q, base_q, limit_q);
        empty     = (rd_q == wr_q);
        full      = (wr_nxt == rd_q);
        push_fire = push_req && !full  && !cfg_load;
        pop_fire  = pop_req  && !empty && !cfg_load;
    end

    // Window bounds register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q  <= RST_BASE;
            limit_q <= RST_LIMIT;
        end else if (cfg_load) begin
            base_q  <= cfg_base;
            limit_q <= cfg_limit;
        end
    end

    // Read and write pointers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= RST_BASE;
            wr_q <= RST_BASE;
        end else if (cfg_load) begin
            rd_q <= cfg_base;
            wr_q <= cfg_base;
        end else begin
            if (push_fire) wr_q <= wr_nxt;
            if (pop_fire)  rd_q <= rd_nxt;
        end
    end

    // Sticky overflow flag: set by a refused push, cleared by setup
    always_ff @(posedge clk) begin
        if (!rst_n)                      ovf_q <= 1'b0;
        else if (cfg_load)               ovf_q <= 1'b0;
        else if (push_req && full)       ovf_q <= 1'b1;
    end

    assign rd_ptr = rd_q;
    assign wr_ptr = wr_q;
    assign ovf    = ovf_q;

endmodule

// File: rtl/cmdq_word_mem.sv
// Module: shared word memory with one write port, one registered read
// port for pops and one combinational read port for debug peeks.
// Assumes at most one write per cycle; contents are not reset.
module cmdq_word_mem #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 9,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata,
    input  logic [ADDR_W-1:0] paddr,
    output logic [DATA_W-1:0] pdata
);

    logic [DATA_W-1:0] store [DEPTH];
    logic [DATA_W-1:0] rdata_q;

    // Array write
    always_ff @(posedge clk) begin
        if (we) store[waddr] <= wdata;
    end

    // Registered pop read
    always_ff @(posedge clk) begin
        if (!rst_n)  rdata_q <= '0;
        else if (re) rdata_q <= store[raddr];
    end

    // Combinational peek read
    assign pdata = store[paddr];
    assign rdata = rdata_q;

endmodule

// File: rtl/cmdq_peek_unit.sv
// Module: debug peek path. Holds the peek control word and returns the
// selected channel's pointers and the word at the peek address.
// Assumes channel numbers at or above NUM_CH select nothing.
module cmdq_peek_unit
    import cmdq_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int DATA_W = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ctrl_we,
    input  logic [REG_W-1:0]         ctrl_wdata,
    input  logic [NUM_CH-1:0][FIELD_W-1:0] rd_ptrs,
    input  logic [NUM_CH-1:0][FIELD_W-1:0] wr_ptrs,
    input  logic [DATA_W-1:0]        mem_word,
    output ptr_t                     mem_addr,
    output logic [REG_W-1:0]         peek_ptrs,
    output logic [DATA_W-1:0]        peek_data
);

    peek_sel_t sel_q;
    ptr_t      rd_sel, wr_sel;
    logic      live;

    wire unused_ctrl_bits = ^{ctrl_wdata[30:19], ctrl_wdata[15:9]};

    // Peek control register
    always_ff @(posedge clk) begin
        if (!rst_n) sel_q <= '0;
        else if (ctrl_we) begin
            sel_q.en   <= ctrl_wdata[PEEK_EN_BIT];
            sel_q.ch   <= ctrl_wdata[PEEK_CH_LSB +: PEEK_CH_W];
            sel_q.addr <= field_lo(ctrl_wdata);
        end
    end

    // Channel pointer select
    always_comb begin
        rd_sel = '0;
        wr_sel = '0;
        live   = 1'b0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (sel_q.ch == PEEK_CH_W'(c)) begin
                rd_sel = rd_ptrs[c];
                wr_sel = wr_ptrs[c];
                live   = sel_q.en;
            end
        end
    end

    // Peek outputs, zero while not enabled
    always_comb begin
        peek_ptrs = live ? pack_pair(rd_sel, wr_sel) : '0;
        peek_data = live ? mem_word : '0;
    end

    assign mem_addr = sel_q.addr;

endmodule

// File: rtl/cmdq_ring_bank.sv
// Module: top of the multi-channel ring command queue. Instantiates one
// ring controller per channel, the shared word memory and the peek path.
// Assumes NUM_CH <= 8 and that programmed windows lie within the memory.
module cmdq_ring_bank
    import cmdq_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int DATA_W = 32,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CH_W-1:0]   cfg_ch,
    input  logic [31:0]       cfg_wdata,
    input  logic              push_valid,
    input  logic [CH_W-1:0]   push_ch,
    input  logic [DATA_W-1:0] push_data,
    output logic              push_ready,
    output logic [NUM_CH-1:0] ovf_flags,
    input  logic              pop_req,
    input  logic [CH_W-1:0]   pop_ch,
    output logic              pop_valid,
    output logic [DATA_W-1:0] pop_data,
    input  logic              peek_we,
    input  logic [31:0]       peek_wdata,
    output logic [31:0]       peek_ptrs,
    output logic [DATA_W-1:0] peek_data,
    input  logic [CH_W-1:0]   stat_ch,
    output logic [31:0]       stat_word
);

    localparam int PTR_W     = FIELD_W;
    localparam int MEM_DEPTH = 1 << PTR_W;
    localparam int WIN       = MEM_DEPTH / NUM_CH;

    logic [NUM_CH-1:0] push_hit, pop_hit, cfg_hit;
    logic [NUM_CH-1:0] push_fire, pop_fire, ch_empty, ch_full;
    logic [NUM_CH-1:0][PTR_W-1:0] rd_ptr_q, wr_ptr_q;
    ptr_t cfg_base, cfg_limit;
    ptr_t mem_waddr, mem_raddr, mem_paddr;
    logic [DATA_W-1:0] mem_pword;
    logic pop_valid_q;

    wire unused_cfg_bits = ^{cfg_wdata[31:25], cfg_wdata[15:9]};

    assign cfg_base  = field_lo(cfg_wdata);
    assign cfg_limit = field_hi(cfg_wdata);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        localparam ptr_t RB = ptr_t'(c * WIN);
        localparam ptr_t RL = ptr_t'(c * WIN + WIN - 1);

        assign push_hit[c] = push_valid && (push_ch == CH_W'(c));
        assign pop_hit[c]  = pop_req    && (pop_ch  == CH_W'(c));
        assign cfg_hit[c]  = cfg_we     && (cfg_ch  == CH_W'(c));

        cmdq_chan_ctl #(
            .RST_BASE  (RB),
            .RST_LIMIT (RL)
        ) u_ctl (
            .clk       (clk),
            .rst_n     (rst_n),
            .cfg_load  (cfg_hit[c]),
            .cfg_base  (cfg_base),
            .cfg_limit (cfg_limit),
            .push_req  (push_hit[c]),
            .pop_req   (pop_hit[c]),
            .rd_ptr    (rd_ptr_q[c]),
            .wr_ptr    (wr_ptr_q[c]),
            .empty     (ch_empty[c]),
            .full      (ch_full[c]),
            .push_fire (push_fire[c]),
            .pop_fire  (pop_fire[c]),
            .ovf       (ovf_flags[c])
        );
    end

    // Memory addresses from the single firing push and pop channel
    always_comb begin
        mem_waddr = '0;
        mem_raddr = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (push_fire[c]) mem_waddr = mem_waddr | wr_ptr_q[c];
            if (pop_fire[c])  mem_raddr = mem_raddr | rd_ptr_q[c];
        end
    end

    // Ready of the channel addressed by push_ch, and status of stat_ch
    always_comb begin
        push_ready = 1'b0;
        stat_word  = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (push_ch == CH_W'(c)) push_ready = !ch_full[c];
            if (stat_ch == CH_W'(c)) stat_word[STAT_EMPTY_BIT] = ch_empty[c];
        end
    end

    // Pop result valid flag, aligned with the registered memory read
    always_ff @(posedge clk) begin
        if (!rst_n) pop_valid_q <= 1'b0;
        else        pop_valid_q <= |pop_fire;
    end

    cmdq_word_mem #(
        .DATA_W (DATA_W),
        .ADDR_W (PTR_W)
    ) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (|push_fire),
        .waddr (mem_waddr),
        .wdata (push_data),
        .re    (|pop_fire),
        .raddr (mem_raddr),
        .rdata (pop_data),
        .paddr (mem_paddr),
        .pdata (mem_pword)
    );

    cmdq_peek_unit #(
        .NUM_CH (NUM_CH),
        .DATA_W (DATA_W)
    ) u_peek (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_we    (peek_we),
        .ctrl_wdata (peek_wdata),
        .rd_ptrs    (rd_ptr_q),
        .wr_ptrs    (wr_ptr_q),
        .mem_word   (mem_pword),
        .mem_addr   (mem_paddr),
        .peek_ptrs  (peek_ptrs),
        .peek_data  (peek_data)
    );

    assign pop_valid = pop_valid_q;

endmodule

// File: rtl/cmdq_ring_bank_chk.sv
// Module: property checker for cmdq_ring_bank, attached with bind.
// Relates request ports, per-channel pointer state and outputs over time.
module cmdq_ring_bank_chk #(
    parameter int NUM_CH = 8,
    parameter int CH_W   = 3,
    parameter int PTR_W  = 9
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           cfg_we,
    input logic [CH_W-1:0]                cfg_ch,
    input logic                           push_valid,
    input logic [CH_W-1:0]                push_ch,
    input logic                           push_ready,
    input logic [NUM_CH-1:0]              ovf_flags,
    input logic                           pop_req,
    input logic [CH_W-1:0]                pop_ch,
    input logic                           pop_valid,
    input logic [CH_W-1:0]                stat_ch,
    input logic [31:0]                    stat_word,
    input logic [NUM_CH-1:0][PTR_W-1:0]   rd_ptr_q,
    input logic [NUM_CH-1:0][PTR_W-1:0]   wr_ptr_q
);

    // R4: a refused push raises that channel's overflow flag
    a_r4_refused_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        push_valid && !push_ready && !(cfg_we && cfg_ch == push_ch)
        |=> ovf_flags[$past(push_ch)]);

    // R6: a pop on an empty channel produces no valid word
    a_r6_empty_pop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        pop_req && (rd_ptr_q[pop_ch] == wr_ptr_q[pop_ch]) |=> !pop_valid);

    // R5: a pop on a non-empty channel produces a valid word next cycle
    a_r5_pop_delivers: assert property (@(posedge clk) disable iff (!rst_n)
        pop_req && (rd_ptr_q[pop_ch] != wr_ptr_q[pop_ch]) && !(cfg_we && cfg_ch == pop_ch)
        |=> pop_valid);

    // R10: status empty bit tracks pointer equality of the shown channel
    a_r10_status_empty: assert property (@(posedge clk) disable iff (!rst_n)
        stat_word[10] == (rd_ptr_q[stat_ch] == wr_ptr_q[stat_ch]));

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        // R4: overflow flag holds until a setup write to its channel
        a_r4_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            ovf_flags[c] && !(cfg_we && cfg_ch == CH_W'(c)) |=> ovf_flags[c]);

        // R9 / R11: without traffic to this channel its pointers stay put
        a_r9_ptrs_hold: assert property (@(posedge clk) disable iff (!rst_n)
            !(push_valid && push_ch == CH_W'(c)) && !(pop_req && pop_ch == CH_W'(c))
            && !(cfg_we && cfg_ch == CH_W'(c))
            |=> $stable(rd_ptr_q[c]) && $stable(wr_ptr_q[c]));
    end

endmodule

bind cmdq_ring_bank cmdq_ring_bank_chk #(
    .NUM_CH (NUM_CH),
    .CH_W   (CH_W),
    .PTR_W  (PTR_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_ch     (cfg_ch),
    .push_valid (push_valid),
    .push_ch    (push_ch),
    .push_ready (push_ready),
    .ovf_flags  (ovf_flags),
    .pop_req    (pop_req),
    .pop_ch     (pop_ch),
    .pop_valid  (pop_valid),
    .stat_ch    (stat_ch),
    .stat_word  (stat_word),
    .rd_ptr_q   (rd_ptr_q),
    .wr_ptr_q   (wr_ptr_q)
);

// File: tb/cmdq_ring_bank_bench.sv
`timescale 1ns/1ps
module cmdq_ring_bank_bench;

    localparam int NCH = 4;
    localparam int DW  = 16;
    localparam int CW  = 2;
    localparam int WIN = 512 / NCH;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cfg_we;
    logic [CW-1:0] cfg_ch;
    logic [31:0]   cfg_wdata;
    logic          push_valid;
    logic [CW-1:0] push_ch;
    logic [DW-1:0] push_data;
    logic          push_ready;
    logic [NCH-1:0] ovf_flags;
    logic          pop_req;
    logic [CW-1:0] pop_ch;
    logic          pop_valid;
    logic [DW-1:0] pop_data;
    logic          peek_we;
    logic [31:0]   peek_wdata;
    logic [31:0]   peek_ptrs;
    logic [DW-1:0] peek_data;
    logic [CW-1:0] stat_ch;
    logic [31:0]   stat_word;

    int n_tests = 0;
    int n_fail  = 0;

    int mrd [NCH];
    int mwr [NCH];
    int mb  [NCH];
    int ml  [NCH];
    bit movf[NCH];
    logic [DW-1:0] mmem [512];
    bit wrt [512];

    always #2 clk = ~clk;

    cmdq_ring_bank #(.NUM_CH(NCH), .DATA_W(DW)) u_cmdq_ring_bank (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_wdata(cfg_wdata),
        .push_valid(push_valid), .push_ch(push_ch), .push_data(push_data),
        .push_ready(push_ready), .ovf_flags(ovf_flags),
        .pop_req(pop_req), .pop_ch(pop_ch), .pop_valid(pop_valid), .pop_data(pop_data),
        .peek_we(peek_we), .peek_wdata(peek_wdata), .peek_ptrs(peek_ptrs),
        .peek_data(peek_data), .stat_ch(stat_ch), .stat_word(stat_word)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic int nxt(input int p, input int b, input int l);
        return (p == l) ? b : p + 1;
    endfunction

    task automatic set_peek(input bit en, input int ch, input int addr);
        peek_we    = 1'b1;
        peek_wdata = {en, 12'd0, 3'(ch), 7'd0, 9'(addr)};
        @(negedge clk);
        peek_we    = 1'b0;
    endtask

    task automatic check_ptrs(input int ch, input string tag);
        set_peek(1'b1, ch, 0);
        chk(tag, peek_ptrs, {7'd0, 9'(mwr[ch]), 7'd0, 9'(mrd[ch])});
    endtask

    task automatic do_cfg(input int ch, input int b, input int l);
        cfg_we    = 1'b1;
        cfg_ch    = CW'(ch);
        cfg_wdata = {7'd0, 9'(l), 7'd0, 9'(b)};
        @(negedge clk);
        cfg_we = 1'b0;
        mb[ch] = b; ml[ch] = l; mrd[ch] = b; mwr[ch] = b; movf[ch] = 1'b0;
    endtask

    task automatic do_push(input int ch, input logic [DW-1:0] d);
        int n;
        bit ok;
        n  = nxt(mwr[ch], mb[ch], ml[ch]);
        ok = (n != mrd[ch]);
        push_valid = 1'b1;
        push_ch    = CW'(ch);
        push_data  = d;
        #1;
        chk("R4 push_ready", {31'd0, push_ready}, {31'd0, ok});
        @(negedge clk);
        push_valid = 1'b0;
        if (ok) begin
            mmem[mwr[ch]] = d;
            wrt[mwr[ch]]  = 1'b1;
            mwr[ch]       = n;
        end else begin
            movf[ch] = 1'b1;
        end
        chk("R4 overflow flag", {31'd0, ovf_flags[ch]}, {31'd0, movf[ch]});
    endtask

    task automatic do_pop(input int ch);
        bit has;
        has     = (mrd[ch] != mwr[ch]);
        pop_req = 1'b1;
        pop_ch  = CW'(ch);
        @(negedge clk);
        pop_req = 1'b0;
        if (has) begin
            chk("R5 pop_valid", {31'd0, pop_valid}, 32'd1);
            chk("R5 pop_data order", {16'd0, pop_data}, {16'd0, mmem[mrd[ch]]});
            mrd[ch] = nxt(mrd[ch], mb[ch], ml[ch]);
        end else begin
            chk("R6 pop_valid on empty", {31'd0, pop_valid}, 32'd0);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cfg_we = 1'b0; cfg_ch = '0; cfg_wdata = '0;
        push_valid = 1'b0; push_ch = '0; push_data = '0;
        pop_req = 1'b0; pop_ch = '0; peek_we = 1'b0; peek_wdata = '0; stat_ch = '0;
        for (int c = 0; c < NCH; c++) begin
            mb[c] = c * WIN; ml[c] = c * WIN + WIN - 1;
            mrd[c] = mb[c]; mwr[c] = mb[c]; movf[c] = 1'b0;
        end
        for (int a = 0; a < 512; a++) begin mmem[a] = '0; wrt[a] = 1'b0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R7: peek outputs are zero before any enable
        chk("R7 peek_ptrs disabled", peek_ptrs, 32'd0);
        chk("R7 peek_data disabled", {16'd0, peek_data}, 32'd0);

        // R1 / R10: reset windows, empty status, clear flags
        chk("R1 overflow flags", {28'd0, ovf_flags}, 32'd0);
        for (int c = 0; c < NCH; c++) begin
            check_ptrs(c, "R1 reset pointers (R8 layout)");
            stat_ch = CW'(c);
            #1;
            chk("R10 status empty after reset", stat_word, 32'h400);
        end

        // R2..R6: sweep on a 4-word window (capacity 3)
        do_cfg(1, 20, 23);
        check_ptrs(1, "R2 setup loads pointers");
        for (int i = 0; i < 80; i++) begin
            bit pushop;
            pushop = (i < 40) ? ((i % 5) != 2 && (i % 5) != 4) : ((i % 5) == 0);
            if (pushop) do_push(1, DW'(16'hA000 + i));
            else        do_pop(1);
            check_ptrs(1, "R3 ring pointers after op");
            stat_ch = 2'd1;
            #1;
            chk("R10 status tracks empty", stat_word, (mrd[1] == mwr[1]) ? 32'h400 : 32'h0);
        end
        chk("R4 flag still set after drain", {31'd0, ovf_flags[1]}, {31'd0, movf[1]});

        // R9: peek every word of the small window, pointers untouched
        for (int a = 20; a <= 23; a++) begin
            if (wrt[a]) begin
                set_peek(1'b1, 1, a);
                chk("R9 peek_data word", {16'd0, peek_data}, {16'd0, mmem[a]});
            end
        end
        check_ptrs(1, "R9 peek leaves pointers");

        // R2: a setup write clears overflow and reloads pointers
        do_cfg(1, 20, 23);
        chk("R2 overflow cleared", {31'd0, ovf_flags[1]}, 32'd0);
        check_ptrs(1, "R2 pointers reloaded");

        // R3 / R4 / R5: fill the top window, wrap from address 511
        for (int k = 0; k < 130; k++) do_push(3, DW'(16'h3000 + k));
        check_ptrs(3, "R4 full window pointers");
        set_peek(1'b1, 3, 400);
        chk("R9 peek_data default window", {16'd0, peek_data}, 32'h3010);
        for (int k = 0; k < 128; k++) do_pop(3);
        do_push(3, DW'(16'h5A5A));
        do_push(3, DW'(16'h5A5B));
        check_ptrs(3, "R3 write pointer wrapped to base");
        do_pop(3);
        check_ptrs(3, "R5 read pointer wrapped to base");

        // R11: untouched channels keep reset state
        check_ptrs(0, "R11 channel 0 unchanged");
        check_ptrs(2, "R11 channel 2 unchanged");
        chk("R11 other flags clear", {28'd0, ovf_flags & 4'b0101}, 32'd0);

        // R7: disabled or out-of-range peek selects read zero
        set_peek(1'b0, 3, 400);
        chk("R7 disabled peek_ptrs", peek_ptrs, 32'd0);
        chk("R7 disabled peek_data", {16'd0, peek_data}, 32'd0);
        set_peek(1'b1, 5, 400);
        chk("R7 out-of-range channel", peek_ptrs, 32'd0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule